// File: doc/BRIEF.md
# Key Slot Push Engine

This block moves a stored 128-bit key out to a hardware consumer without ever routing it through the processor. Software selects a slot elsewhere and then strobes a task register. The engine first checks whether the slot may be pushed. The checks cover the slot ID, whether the slot is revoked, the push and write permissions, and whether a destination exists. If every check passes, the engine copies the key as four 32-bit writes over its own APB master port to the slot's destination address.

Each push ends in exactly one outcome: pushed, revoked or error. Each outcome sets its own sticky event flag. Each flag has an interrupt enable, which can be written directly or through set and clear aliases. A read-only pending view combines the flags with the enables, and the interrupt output is the OR of the pending bits.

The register port is a single-cycle write strobe with a combinational read. Its data is only as wide as the number of events, so every register fits in three bits.

The sequencer has four states:
- `S_IDLE`: waits for a start request (IDLE→CHECK).
- `S_CHECK`: evaluates the slot. It returns to IDLE when the push is refused (CHECK→IDLE) and otherwise starts beat 0 (CHECK→SETUP).
- `S_SETUP`: the APB setup phase. It always moves on (SETUP→ACCESS).
- `S_ACCESS`: the APB access phase. It holds while PREADY is low (ACCESS→ACCESS). It goes to the next beat after a good response on beats 0 to 2 (ACCESS→SETUP). It finishes after a good fourth beat or after an error response (ACCESS→IDLE).

Top module: `keyslot_push_engine`

## Requirements
- R1: A write to register index 0 with data bit 0 set starts a push, but only while the engine is idle. A write with bit 0 clear, or any write during a push, has no effect. Index 0 always reads as 0.
- R2: A selected ID of 0 means no slot is selected. This check runs first, before every other check. It raises the error event (event bit 2), and the APB port performs no transfer.
- R3: For a nonzero ID whose active bit is 0 (revoked), the engine raises only the revoked event (event bit 1), whatever the permissions and destination are. No transfer takes place.
- R4: The engine refuses an active slot and raises the error event with no transfer in any of these cases: push enable is 0, write enable is 1, or the destination equals 0xFFFFFFFF.
- R5: An accepted push makes four APB writes in order, to destination plus 0, 4, 8 and 12. Each write carries key bits [32k+31:32k] for beat k. Every write has a setup phase (PSEL high, PENABLE low) followed by an access phase (both high), and PWRITE is high.
- R6: While PREADY is low in the access phase, the engine holds PSEL, PENABLE, PADDR and PWDATA unchanged.
- R7: A PSLVERR response on any beat ends the sequence. No further beats follow, the error event is raised and the pushed event is not.
- R8: A push in which all four beats complete without an error raises the pushed event (event bit 0). Only one event is raised per push.
- R9: Event flags sit at register indices 1 (pushed), 2 (revoked) and 3 (error). Each flag stays set until software writes a new value into bit 0 of its register. A hardware set in the same cycle wins over a software write.
- R10: The interrupt enable bits are bit 0 for pushed, bit 1 for revoked and bit 2 for error. Index 4 loads them directly, index 5 sets the bits written as 1, and index 6 clears the bits written as 1. All three indices read back the enables.
- R11: Index 7 reads the AND of the event flags with the enables, and writes to it are ignored. The irq output is high exactly when any of these pending bits is high.
- R12: After reset, every flag and enable is 0, irq is low and PSEL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data (combinational) |
| irq | output | 1 | Interrupt, OR of the pending bits |
| slot_id | input | 8 | Selected slot ID, where 0 means none |
| slot_active | input | 1 | Slot state: 1 for active, 0 for revoked |
| slot_push_en | input | 1 | Slot push permission |
| slot_write_en | input | 1 | Slot write permission |
| slot_dest | input | 32 | Slot destination address |
| slot_key | input | 128 | Slot key value |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write |
| paddr | output | 32 | APB address |
| pwdata | output | 32 | APB write data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
The embedded properties assume that the slot inputs (ID, state, permissions, destination, key) stay constant from the task write until the push's outcome event is raised. They also assume that the APB slave asserts PSLVERR only together with PREADY, and only in the access phase. The bench respects both assumptions. It changes slot inputs only after it has seen the outcome through irq and the event registers. Its slave model drives PREADY and PSLVERR only in access-phase cycles, after a programmed number of wait cycles, and lowers them at once afterwards.

// File: rtl/kpe_pkg.sv
package kpe_pkg;

    localparam int NUM_EV = 3;
    localparam int REG_AW = 3;

    // Event bit positions
    localparam int EV_PUSH = 0;
    localparam int EV_REV  = 1;
    localparam int EV_ERR  = 2;

    // Register indices
    localparam logic [REG_AW-1:0] RA_TASK    = 3'd0;
    localparam logic [REG_AW-1:0] RA_EV_BASE = 3'd1;
    localparam logic [REG_AW-1:0] RA_INTEN   = 3'd4;
    localparam logic [REG_AW-1:0] RA_INTSET  = 3'd5;
    localparam logic [REG_AW-1:0] RA_INTCLR  = 3'd6;
    localparam logic [REG_AW-1:0] RA_PEND    = 3'd7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_SETUP,
        S_ACCESS
    } kpe_state_e;

endpackage

// File: rtl/kpe_regs.sv
module kpe_regs
    import kpe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NUM_EV-1:0] reg_wdata,
    output logic [NUM_EV-1:0] reg_rdata,
    input  logic [NUM_EV-1:0] ev_set,
    output logic              start,
    output logic              irq
);

    logic [NUM_EV-1:0] evt_q;
    logic [NUM_EV-1:0] inten_q;
    logic [NUM_EV-1:0] pend;

    assign start = reg_we && (reg_addr == RA_TASK) && reg_wdata[0];
    assign pend  = evt_q & inten_q;
    assign irq   = |pend;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_evt
        localparam logic [REG_AW-1:0] MY_ADDR = RA_EV_BASE + REG_AW'(g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                evt_q[g] <= 1'b0;
            else if (ev_set[g])
                evt_q[g] <= 1'b1;
            else if (reg_we && reg_addr == MY_ADDR)
                evt_q[g] <= reg_wdata[0];
        end

        // R9: a flag stays set unless its own register is written
        p_event_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_q[g] && !(reg_we && reg_addr == MY_ADDR)) |=> evt_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inten_q <= '0;
        else if (reg_we) begin
            unique case (reg_addr)
                RA_INTEN:  inten_q <= reg_wdata;
                RA_INTSET: inten_q <= inten_q | reg_wdata;
                RA_INTCLR: inten_q <= inten_q & ~reg_wdata;
                default:   inten_q <= inten_q;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_TASK:                        reg_rdata = '0;
            RA_INTEN, RA_INTSET, RA_INTCLR: reg_rdata = inten_q;
            RA_PEND:                        reg_rdata = pend;
            default:                        reg_rdata = NUM_EV'(evt_q[reg_addr - RA_EV_BASE]);
        endcase
    end

    // R10: the set alias leaves every written-1 bit enabled
    p_inten_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_INTSET) |=>
        ((inten_q & $past(reg_wdata)) == $past(reg_wdata)));

    // R10: the clear alias leaves every written-1 bit disabled
    p_inten_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_INTCLR) |=> ((inten_q & $past(reg_wdata)) == '0));

endmodule

// File: rtl/kpe_seq.sv
module kpe_seq
    import kpe_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int KEY_W  = DATA_W * BEATS,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int STEP   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   slot_id,
    input  logic              slot_active,
    input  logic              slot_push_en,
    input  logic              slot_write_en,
    input  logic [ADDR_W-1:0] slot_dest,
    input  logic [KEY_W-1:0]  slot_key,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic              pready,
    input  logic              pslverr,
    output logic [NUM_EV-1:0] ev_set
);

    kpe_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              no_slot, revoked, refused, slot_ok, last_beat;

    assign no_slot   = (slot_id == '0);
    assign revoked   = !slot_active;
    assign refused   = !slot_push_en || slot_write_en || (slot_dest == '1);
    assign slot_ok   = !no_slot && !revoked && !refused;
    assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_CHECK;
            S_CHECK:  state_d = slot_ok ? S_SETUP : S_IDLE;
            S_SETUP:  state_d = S_ACCESS;
            S_ACCESS: if (pready) state_d = (pslverr || last_beat) ? S_IDLE : S_SETUP;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CHECK)
                beat_q <= '0;
            else if (state_q == S_ACCESS && pready && !pslverr && !last_beat)
                beat_q <= beat_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        psel    = 1'b0;
        penable = 1'b0;
        ev_set  = '0;
        unique case (state_q)
            S_IDLE: ;
            S_CHECK: begin
                if (no_slot)      ev_set[EV_ERR] = 1'b1;
                else if (revoked) ev_set[EV_REV] = 1'b1;
                else if (refused) ev_set[EV_ERR] = 1'b1;
            end
            S_SETUP: psel = 1'b1;
            S_ACCESS: begin
                psel    = 1'b1;
                penable = 1'b1;
                if (pready) begin
                    if (pslverr)        ev_set[EV_ERR]  = 1'b1;
                    else if (last_beat) ev_set[EV_PUSH] = 1'b1;
                end
            end
            default: ;
        endcase
        pwrite = psel;
        paddr  = slot_dest + ADDR_W'(beat_q) * ADDR_W'(STEP);
        pwdata = slot_key[beat_q*DATA_W +: DATA_W];
    end

    // R5: access phase only under select
    p_penable_with_psel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

    // R5: setup phase is followed by an access phase
    p_setup_to_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // R6: bus held while slave waits
    p_hold_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=>
        (psel && penable && $stable(paddr) && $stable(pwdata)));

    // R7: an error response ends the transfer
    p_err_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && pslverr) |=> !psel);

    // R8: at most one outcome per cycle
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_set));

endmodule

// File: rtl/keyslot_push_engine.sv
module keyslot_push_engine
    import kpe_pkg::*;
#(
    parameter int ID_W   = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    localparam int KEY_W  = DATA_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [NUM_EV-1:0] reg_wdata,
    output logic [NUM_EV-1:0] reg_rdata,
    output logic              irq,
    input  logic [ID_W-1:0]   slot_id,
    input  logic              slot_active,
    input  logic              slot_push_en,
    input  logic              slot_write_en,
    input  logic [ADDR_W-1:0] slot_dest,
    input  logic [KEY_W-1:0]  slot_key,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    input  logic              pready,
    input  logic              pslverr
);

    logic              start;
    logic [NUM_EV-1:0] ev_set;

    kpe_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_set    (ev_set),
        .start     (start),
        .irq       (irq)
    );

    kpe_seq #(
        .ID_W   (ID_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .slot_id       (slot_id),
        .slot_active   (slot_active),
        .slot_push_en  (slot_push_en),
        .slot_write_en (slot_write_en),
        .slot_dest     (slot_dest),
        .slot_key      (slot_key),
        .psel          (psel),
        .penable       (penable),
        .pwrite        (pwrite),
        .paddr         (paddr),
        .pwdata        (pwdata),
        .pready        (pready),
        .pslverr       (pslverr),
        .ev_set        (ev_set)
    );

endmodule

// File: tb/tb_keyslot_push_engine.sv
module tb_keyslot_push_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [2:0]   reg_wdata = 3'd0;
    logic [2:0]   reg_rdata;
    logic         irq;
    logic [7:0]   slot_id = 8'd0;
    logic         slot_active = 1'b1;
    logic         slot_push_en = 1'b1;
    logic         slot_write_en = 1'b0;
    logic [31:0]  slot_dest = 32'h0;
    logic [127:0] slot_key = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    logic         psel, penable, pwrite;
    logic [31:0]  paddr, pwdata;
    logic         pready = 1'b0;
    logic         pslverr = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    keyslot_push_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .slot_id(slot_id), .slot_active(slot_active), .slot_push_en(slot_push_en),
        .slot_write_en(slot_write_en), .slot_dest(slot_dest), .slot_key(slot_key),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .pready(pready), .pslverr(pslverr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // APB slave model
    int          cfg_wait = 0;
    int          cfg_errb = 7;
    int          cur_base = 0;
    int          nbeat = 0;
    int          wcnt = 0;
    logic [31:0] rec_addr [0:63];
    logic [31:0] rec_data [0:63];
    bit          rec_wr   [0:63];

    always @(negedge clk) begin
        if (psel && penable && !pready) begin
            if (wcnt >= cfg_wait) begin
                pready  <= 1'b1;
                pslverr <= ((nbeat - cur_base) == cfg_errb);
                if (nbeat < 64) begin
                    rec_addr[nbeat] <= paddr;
                    rec_data[nbeat] <= pwdata;
                    rec_wr[nbeat]   <= pwrite;
                end
                nbeat <= nbeat + 1;
                wcnt  <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            pready  <= 1'b0;
            pslverr <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [2:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [2:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    typedef struct packed {
        logic [7:0]  id;
        logic        act;
        logic        pen;
        logic        wen;
        logic [31:0] dest;
        logic [2:0]  wt;
        logic [2:0]  errb;   // 7 = no error
        logic [2:0]  ev;     // {error, revoked, pushed}
        logic [2:0]  nb;     // beats seen by the slave
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd5,   1'b1, 1'b1, 1'b0, 32'h4000_1000, 3'd0, 3'd7, 3'b001, 3'd4},
        '{8'd7,   1'b1, 1'b1, 1'b0, 32'h2000_0100, 3'd2, 3'd7, 3'b001, 3'd4},
        '{8'd0,   1'b1, 1'b1, 1'b0, 32'h4000_1000, 3'd0, 3'd7, 3'b100, 3'd0},
        '{8'd3,   1'b0, 1'b1, 1'b0, 32'h4000_1000, 3'd0, 3'd7, 3'b010, 3'd0},
        '{8'd3,   1'b1, 1'b0, 1'b0, 32'h4000_1000, 3'd0, 3'd7, 3'b100, 3'd0},
        '{8'd3,   1'b1, 1'b1, 1'b1, 32'h4000_1000, 3'd0, 3'd7, 3'b100, 3'd0},
        '{8'd3,   1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 3'd0, 3'd7, 3'b100, 3'd0},
        '{8'd9,   1'b1, 1'b1, 1'b0, 32'h5000_0040, 3'd1, 3'd2, 3'b100, 3'd3},
        '{8'd9,   1'b1, 1'b1, 1'b0, 32'h5000_0040, 3'd0, 3'd0, 3'b100, 3'd1},
        '{8'd128, 1'b1, 1'b1, 1'b0, 32'h6000_0000, 3'd0, 3'd3, 3'b100, 3'd4},
        '{8'd0,   1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 3'd0, 3'd7, 3'b100, 3'd0},
        '{8'd11,  1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 3'd0, 3'd7, 3'b010, 3'd0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        logic [2:0] d;
        logic [2:0] evs;
        int b0;

        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        chk("R12 irq", irq, 0);
        chk("R12 psel", psel, 0);
        rst_n = 1'b1;
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d);
            chk("R12 register", d, 0);
        end

        // R10: enable register and its aliases
        wr(3'd4, 3'b101); rd(3'd4, d); chk("R10 direct", d, 3'b101);
        wr(3'd5, 3'b010); rd(3'd5, d); chk("R10 set", d, 3'b111);
        wr(3'd6, 3'b001); rd(3'd6, d); chk("R10 clear", d, 3'b110);
        wr(3'd4, 3'b000);

        // R11/R9: pending view, read-only, sticky flag written by software
        wr(3'd2, 3'b001);
        rd(3'd7, d); chk("R11 pending masked", d, 3'b000);
        chk("R11 irq masked", irq, 0);
        wr(3'd5, 3'b010);
        rd(3'd7, d); chk("R11 pending", d, 3'b010);
        chk("R11 irq", irq, 1);
        wr(3'd7, 3'b000);
        rd(3'd7, d); chk("R11 pending read-only", d, 3'b010);
        repeat (5) @(negedge clk);
        rd(3'd2, d); chk("R9 flag sticky", d, 3'b001);
        wr(3'd2, 3'b000);
        rd(3'd2, d); chk("R9 flag cleared", d, 3'b000);
        chk("R11 irq cleared", irq, 0);

        // R1: task write with bit 0 clear does nothing
        slot_id = 8'd4; slot_dest = 32'h1000_0000; cfg_wait = 0; cfg_errb = 7;
        cur_base = nbeat; b0 = nbeat;
        wr(3'd0, 3'b010);
        repeat (15) @(negedge clk);
        chk("R1 no start on bit0=0", nbeat - b0, 0);
        rd(3'd1, d); chk("R1 no pushed event", d, 0);
        rd(3'd3, d); chk("R1 no error event", d, 0);

        // R1: task reads 0, and a repeated start during a push is ignored
        wr(3'd4, 3'b111);
        cfg_wait = 4; cur_base = nbeat; b0 = nbeat;
        wr(3'd0, 3'b001);
        rd(3'd0, d); chk("R1 task reads 0", d, 0);
        repeat (2) @(negedge clk);
        wr(3'd0, 3'b001);
        wait_irq();
        repeat (40) @(negedge clk);
        chk("R1 busy start ignored", nbeat - b0, 4);
        rd(3'd1, d); chk("R8 pushed after busy test", d, 1);
        wr(3'd1, 3'b000);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
            slot_id = VECS[v].id; slot_active = VECS[v].act;
            slot_push_en = VECS[v].pen; slot_write_en = VECS[v].wen;
            slot_dest = VECS[v].dest;
            slot_key = {32'h0A0B0C0D + 32'(v), 32'h11223344, 32'h55667788 ^ 32'(v), 32'h99AABBCC};
            cfg_wait = int'(VECS[v].wt); cfg_errb = int'(VECS[v].errb);
            cur_base = nbeat; b0 = nbeat;
            wr(3'd0, 3'b001);
            wait_irq();
            rd(3'd1, d); evs[0] = d[0];
            rd(3'd2, d); evs[1] = d[0];
            rd(3'd3, d); evs[2] = d[0];
            // R2 R3 R4 R7 R8: outcome event per vector
            chk($sformatf("R2/R3/R4/R7/R8 event v%0d", v), evs, VECS[v].ev);
            // R5 R7: beat count seen by the slave
            chk($sformatf("R5/R7 beats v%0d", v), nbeat - b0, VECS[v].nb);
            for (int k = 0; k < int'(VECS[v].nb); k++) begin
                // R5 R6: address, data and direction of each beat
                chk($sformatf("R5 addr v%0d b%0d", v, k), rec_addr[b0 + k], VECS[v].dest + 32'(4 * k));
                chk($sformatf("R6 data v%0d b%0d", v, k), rec_data[b0 + k], slot_key[32*k +: 32]);
                chk($sformatf("R5 pwrite v%0d b%0d", v, k), 32'(rec_wr[b0 + k]), 1);
            end
            rd(3'd7, d); chk($sformatf("R11 pending v%0d", v), d, VECS[v].ev);
        end

        done = 1;
        finish_up();
    end

endmodule